// File: doc/BRIEF.md
# Split Depth/Stencil Pixel Packer

This engine copies a three-dimensional box of pixels between one packed staging buffer and a pair of separate surfaces: a depth surface and a surface holding one stencil byte per pixel. In read mode it gathers depth bytes and the stencil byte for every pixel and assembles packed pixels in the staging buffer. In write mode it takes packed pixels from the staging buffer and scatters them back into the two surfaces. The depth surface may be laid out linearly or in either of two 4 KiB tile shapes. The stencil surface always uses a 64x64-byte tile with nested 8x8, 4x4 and 2x2 block interleaving.

The engine steps through the box slice by slice, then row by row, then pixel by pixel. For each pixel it computes surface coordinates and translates them into tiled byte addresses. Each step moves one byte through a holding register: first a read from the source port, then a write to the destination port. Each of the three byte-wide memory ports uses a valid/ready handshake. Read data is taken in the cycle the read request is accepted. A start pulse launches the walk, and a done pulse reports that it has finished.

Top module: `zsp_engine`

## Requirements
- R1: After reset, busy and done are low, and none of the three request valids is asserted.
- R2: A start pulse while idle raises busy in the next cycle. Done is high for exactly one cycle, one cycle after the last transfer is accepted. Busy falls together with done.
- R3: In read mode (dirWrite=0), only the depth and stencil ports are read and only the staging port is written. In write mode (dirWrite=1), only the staging port is read and only the depth and stencil ports are written.
- R4: Mode 1 (24-bit depth with stencil) uses 4-byte packed pixels. Packed bytes 0..2 map to depth-surface bytes at x = 4*(depOrgX+col)+k, and packed byte 3 maps to the stencil byte.
- R5: Mode 2 (32-bit float depth with stencil) uses 8-byte packed pixels. Packed bytes 0..3 map to depth bytes 4*(depOrgX+col)+k, and packed byte 4 maps to the stencil byte. In read mode, packed bytes 5..7 are never written.
- R6: In mode 1 write, the fourth depth byte of each pixel (x = 4*(depOrgX+col)+3) keeps its previous contents.
- R7: Mode 0 (stencil only) moves one byte per pixel, between staging byte 0 and the stencil surface, and issues no depth requests.
- R8: The stencil byte address is tile*4096 + xb*512 + yb*64 + y2*32 + x2*16 + y1*8 + x1*4 + y0*2 + x0. Here tile = (y/64)*(stnPitch/64) + x/64, xb = (x%64)/8, yb = (y%64)/8, and xi, yi are bit i of x and y.
- R9: The depth address depends on depTiling. For 0 (linear) it is y*depPitch + x. For 1 (8-row tile) it is ((y/8)*(depPitch/512) + x/512)*4096 + (y%8)*512 + x%512. For 2 (32-row tile) it is ((y/32)*(depPitch/128) + x/128)*4096 + ((x%128)/16)*512 + (y%32)*16 + x%16.
- R10: For slice s, row r, column c and packed byte b, the surface y coordinates are orgY + s*sliceRows + r. The staging byte address is stgBase + s*stgLayerStride + r*stgRowStride + c*pixelBytes + b.
- R11: A request that is not yet accepted keeps its valid, address and direction stable. Only one port requests at a time. Each pixel takes exactly 2*(depth bytes+1) accepted transfers, so no byte is skipped or repeated.
- R12: A write pass followed by a read pass over the same box returns the original packed bytes in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted while idle |
| dirWrite | input | 1 | 1: staging to surfaces, 0: surfaces to staging |
| mode | input | 2 | 0 stencil only, 1 24-bit depth + stencil, 2 float depth + stencil |
| depTiling | input | 2 | Depth layout: 0 linear, 1 8-row tile, 2 32-row tile |
| boxW | input | DIM_W | Box width in pixels (at least 1) |
| boxH | input | DIM_W | Box height in rows (at least 1) |
| boxD | input | DIM_W | Box depth in slices (at least 1) |
| depOrgX | input | CRD_W | Depth surface origin x in pixels |
| depOrgY | input | CRD_W | Depth surface origin y of slice 0 |
| depSliceRows | input | CRD_W | Depth rows between slice origins |
| depPitch | input | ADDR_W | Depth surface row pitch in bytes |
| stnOrgX | input | CRD_W | Stencil surface origin x |
| stnOrgY | input | CRD_W | Stencil surface origin y of slice 0 |
| stnSliceRows | input | CRD_W | Stencil rows between slice origins |
| stnPitch | input | ADDR_W | Stencil surface row pitch in bytes |
| stgBase | input | ADDR_W | Staging start address |
| stgRowStride | input | ADDR_W | Staging bytes per row |
| stgLayerStride | input | ADDR_W | Staging bytes per slice |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| depValid | output | 1 | Depth request valid |
| depWrite | output | 1 | Depth request is a write |
| depAddr | output | ADDR_W | Depth byte address |
| depWdata | output | 8 | Depth write byte |
| depReady | input | 1 | Depth port accepts |
| depRdata | input | 8 | Depth read byte, valid when accepted |
| stnValid | output | 1 | Stencil request valid |
| stnWrite | output | 1 | Stencil request is a write |
| stnAddr | output | ADDR_W | Stencil byte address |
| stnWdata | output | 8 | Stencil write byte |
| stnReady | input | 1 | Stencil port accepts |
| stnRdata | input | 8 | Stencil read byte |
| stgValid | output | 1 | Staging request valid |
| stgWrite | output | 1 | Staging request is a write |
| stgAddr | output | ADDR_W | Staging byte address |
| stgWdata | output | 8 | Staging write byte |
| stgReady | input | 1 | Staging port accepts |
| stgRdata | input | 8 | Staging read byte |

## Verification
The depth origin is placed so that pixels cross a 128-byte tile column in the 32-row layout and an 8-row tile boundary across slices. The stencil origin straddles the 64-byte tile edge. A wrong tile-number term would therefore land bytes in the wrong tile, and the surface contents would not match the address arithmetic computed in the bench. The ready inputs are randomly withheld, so a walker that advanced on an unaccepted request would change the transfer count or lose bytes. The bench also checks that the fourth depth byte survives a 24-bit write, that packed bytes 5..7 stay untouched on a float-depth read, and that stencil-only mode issues no depth traffic. An engine that used the wrong pixel pitch or stencil lane would corrupt either those neighbouring bytes or the round trip.

// File: rtl/zsp_pkg.sv
package zsp_pkg;

  localparam logic [1:0] MODE_STN = 2'd0;
  localparam logic [1:0] MODE_D24 = 2'd1;
  localparam logic [1:0] MODE_D32 = 2'd2;

  localparam logic [1:0] TILE_LIN  = 2'd0;
  localparam logic [1:0] TILE_ROW8 = 2'd1;
  localparam logic [1:0] TILE_ROW32 = 2'd2;

  localparam int DEP_BPP = 4;

  typedef struct packed {
    logic load;
    logic srcReq;
    logic capture;
    logic dstReq;
    logic step;
  } zsStrobe_t;

  // 4 KiB tile, 8 rows of 512 bytes
  function automatic logic [31:0] offRow8(input logic [31:0] x, input logic [31:0] y,
                                          input logic [31:0] pitch);
    logic [31:0] tile;
    tile = (y >> 3) * (pitch >> 9) + (x >> 9);
    return (tile << 12) | ((y & 32'h7) << 9) | (x & 32'h1ff);
  endfunction

  // 4 KiB tile, 32 rows of 128 bytes, 16-byte units column-major
  function automatic logic [31:0] offRow32(input logic [31:0] x, input logic [31:0] y,
                                           input logic [31:0] pitch);
    logic [31:0] tile;
    tile = (y >> 5) * (pitch >> 7) + (x >> 7);
    return (tile << 12) | ((x & 32'h70) << 5) | ((y & 32'h1f) << 4) | (x & 32'hf);
  endfunction

  // 64x64 byte tile with nested block interleave, used for stencil
  function automatic logic [31:0] offStencil(input logic [31:0] x, input logic [31:0] y,
                                             input logic [31:0] pitch);
    logic [31:0] tile;
    tile = (y >> 6) * (pitch >> 6) + (x >> 6);
    return (tile << 12) | (((x >> 3) & 32'h7) << 9) | (((y >> 3) & 32'h7) << 6)
         | (((y >> 2) & 32'h1) << 5) | (((x >> 2) & 32'h1) << 4)
         | (((y >> 1) & 32'h1) << 3) | (((x >> 1) & 32'h1) << 2)
         | ((y & 32'h1) << 1) | (x & 32'h1);
  endfunction

  function automatic logic [31:0] offDepth(input logic [1:0] tiling, input logic [31:0] x,
                                           input logic [31:0] y, input logic [31:0] pitch);
    case (tiling)
      TILE_ROW8:  return offRow8(x, y, pitch);
      TILE_ROW32: return offRow32(x, y, pitch);
      default:    return y * pitch + x;
    endcase
  endfunction

endpackage

// File: rtl/zsp_ctrl.sv
module zsp_ctrl
  import zsp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      srcAcc,
  input  logic      dstAcc,
  input  logic      lastStep,
  output zsStrobe_t stb,
  output logic      busy,
  output logic      done
);

  typedef enum logic [1:0] {ST_IDLE, ST_SRC, ST_DST, ST_FIN} state_e;
  state_e state, stateNext;

  always_comb begin
    stb = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        stateNext = ST_SRC;
      end
      ST_SRC: begin
        stb.srcReq = 1'b1;
        if (srcAcc) begin
          stb.capture = 1'b1;
          stateNext = ST_DST;
        end
      end
      ST_DST: begin
        stb.dstReq = 1'b1;
        if (dstAcc) begin
          stb.step = !lastStep;
          stateNext = lastStep ? ST_FIN : ST_SRC;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/zsp_datapath.sv
module zsp_datapath
  import zsp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W = 10,
  parameter int CRD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  zsStrobe_t         stb,
  input  logic              dirWrite,
  input  logic [1:0]        mode,
  input  logic [1:0]        depTiling,
  input  logic [DIM_W-1:0]  boxW,
  input  logic [DIM_W-1:0]  boxH,
  input  logic [DIM_W-1:0]  boxD,
  input  logic [CRD_W-1:0]  depOrgX,
  input  logic [CRD_W-1:0]  depOrgY,
  input  logic [CRD_W-1:0]  depSliceRows,
  input  logic [ADDR_W-1:0] depPitch,
  input  logic [CRD_W-1:0]  stnOrgX,
  input  logic [CRD_W-1:0]  stnOrgY,
  input  logic [CRD_W-1:0]  stnSliceRows,
  input  logic [ADDR_W-1:0] stnPitch,
  input  logic [ADDR_W-1:0] stgBase,
  input  logic [ADDR_W-1:0] stgRowStride,
  input  logic [ADDR_W-1:0] stgLayerStride,
  output logic              depValid,
  output logic              depWrite,
  output logic [ADDR_W-1:0] depAddr,
  output logic [7:0]        depWdata,
  input  logic              depReady,
  input  logic [7:0]        depRdata,
  output logic              stnValid,
  output logic              stnWrite,
  output logic [ADDR_W-1:0] stnAddr,
  output logic [7:0]        stnWdata,
  input  logic              stnReady,
  input  logic [7:0]        stnRdata,
  output logic              stgValid,
  output logic              stgWrite,
  output logic [ADDR_W-1:0] stgAddr,
  output logic [7:0]        stgWdata,
  input  logic              stgReady,
  input  logic [7:0]        stgRdata,
  output logic              srcAcc,
  output logic              dstAcc,
  output logic              lastStep
);

  logic [DIM_W-1:0] col, row, slice;
  logic [2:0]       bIdx;
  logic [2:0]       depUsed;
  logic [3:0]       pixBytes;
  logic [7:0]       dataByte, srcData;
  logic             stnStep, colEnd, rowEnd, sliceEnd;
  logic [31:0]      depX, depY, stnX, stnY;

  always_comb begin
    case (mode)
      MODE_D24: begin depUsed = 3'd3; pixBytes = 4'd4; end
      MODE_D32: begin depUsed = 3'd4; pixBytes = 4'd8; end
      default:  begin depUsed = 3'd0; pixBytes = 4'd1; end
    endcase
  end

  // the stencil byte follows the depth bytes of a pixel
  assign stnStep  = (bIdx == depUsed);
  assign colEnd   = (col == boxW - 1'b1);
  assign rowEnd   = (row == boxH - 1'b1);
  assign sliceEnd = (slice == boxD - 1'b1);
  assign lastStep = stnStep && colEnd && rowEnd && sliceEnd;

  always_ff @(posedge clk) begin
    if (!rstN || stb.load) begin
      col <= '0;
      row <= '0;
      slice <= '0;
      bIdx <= '0;
    end else if (stb.step) begin
      if (!stnStep) begin
        bIdx <= bIdx + 3'd1;
      end else begin
        bIdx <= '0;
        if (!colEnd) begin
          col <= col + 1'b1;
        end else begin
          col <= '0;
          if (!rowEnd) begin
            row <= row + 1'b1;
          end else begin
            row <= '0;
            slice <= slice + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    if (dirWrite) srcData = stgRdata;
    else if (stnStep) srcData = stnRdata;
    else srcData = depRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataByte <= '0;
    else if (stb.capture) dataByte <= srcData;
  end

  // surface coordinates of the current byte
  assign depX = (32'(depOrgX) + 32'(col)) * DEP_BPP + 32'(bIdx);
  assign depY = 32'(depOrgY) + 32'(slice) * 32'(depSliceRows) + 32'(row);
  assign stnX = 32'(stnOrgX) + 32'(col);
  assign stnY = 32'(stnOrgY) + 32'(slice) * 32'(stnSliceRows) + 32'(row);

  assign depAddr = ADDR_W'(offDepth(depTiling, depX, depY, 32'(depPitch)));
  assign stnAddr = ADDR_W'(offStencil(stnX, stnY, 32'(stnPitch)));
  assign stgAddr = ADDR_W'(32'(stgBase) + 32'(slice) * 32'(stgLayerStride)
                   + 32'(row) * 32'(stgRowStride) + 32'(col) * 32'(pixBytes) + 32'(bIdx));

  assign depValid = !stnStep && ((stb.srcReq && !dirWrite) || (stb.dstReq && dirWrite));
  assign stnValid = stnStep && ((stb.srcReq && !dirWrite) || (stb.dstReq && dirWrite));
  assign stgValid = (stb.srcReq && dirWrite) || (stb.dstReq && !dirWrite);
  assign depWrite = dirWrite;
  assign stnWrite = dirWrite;
  assign stgWrite = !dirWrite;
  assign depWdata = dataByte;
  assign stnWdata = dataByte;
  assign stgWdata = dataByte;

  assign srcAcc = stb.srcReq && (dirWrite ? stgReady : (stnStep ? stnReady : depReady));
  assign dstAcc = stb.dstReq && (dirWrite ? (stnStep ? stnReady : depReady) : stgReady);

endmodule

// File: rtl/zsp_engine.sv
module zsp_engine
  import zsp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W = 10,
  parameter int CRD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirWrite,
  input  logic [1:0]        mode,
  input  logic [1:0]        depTiling,
  input  logic [DIM_W-1:0]  boxW,
  input  logic [DIM_W-1:0]  boxH,
  input  logic [DIM_W-1:0]  boxD,
  input  logic [CRD_W-1:0]  depOrgX,
  input  logic [CRD_W-1:0]  depOrgY,
  input  logic [CRD_W-1:0]  depSliceRows,
  input  logic [ADDR_W-1:0] depPitch,
  input  logic [CRD_W-1:0]  stnOrgX,
  input  logic [CRD_W-1:0]  stnOrgY,
  input  logic [CRD_W-1:0]  stnSliceRows,
  input  logic [ADDR_W-1:0] stnPitch,
  input  logic [ADDR_W-1:0] stgBase,
  input  logic [ADDR_W-1:0] stgRowStride,
  input  logic [ADDR_W-1:0] stgLayerStride,
  output logic              busy,
  output logic              done,
  output logic              depValid,
  output logic              depWrite,
  output logic [ADDR_W-1:0] depAddr,
  output logic [7:0]        depWdata,
  input  logic              depReady,
  input  logic [7:0]        depRdata,
  output logic              stnValid,
  output logic              stnWrite,
  output logic [ADDR_W-1:0] stnAddr,
  output logic [7:0]        stnWdata,
  input  logic              stnReady,
  input  logic [7:0]        stnRdata,
  output logic              stgValid,
  output logic              stgWrite,
  output logic [ADDR_W-1:0] stgAddr,
  output logic [7:0]        stgWdata,
  input  logic              stgReady,
  input  logic [7:0]        stgRdata
);

  zsStrobe_t stb;
  logic srcAcc, dstAcc, lastStep;

  zsp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcAcc(srcAcc), .dstAcc(dstAcc),
    .lastStep(lastStep), .stb(stb), .busy(busy), .done(done)
  );

  zsp_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .CRD_W(CRD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dirWrite(dirWrite), .mode(mode),
    .depTiling(depTiling), .boxW(boxW), .boxH(boxH), .boxD(boxD),
    .depOrgX(depOrgX), .depOrgY(depOrgY), .depSliceRows(depSliceRows), .depPitch(depPitch),
    .stnOrgX(stnOrgX), .stnOrgY(stnOrgY), .stnSliceRows(stnSliceRows), .stnPitch(stnPitch),
    .stgBase(stgBase), .stgRowStride(stgRowStride), .stgLayerStride(stgLayerStride),
    .depValid(depValid), .depWrite(depWrite), .depAddr(depAddr), .depWdata(depWdata),
    .depReady(depReady), .depRdata(depRdata),
    .stnValid(stnValid), .stnWrite(stnWrite), .stnAddr(stnAddr), .stnWdata(stnWdata),
    .stnReady(stnReady), .stnRdata(stnRdata),
    .stgValid(stgValid), .stgWrite(stgWrite), .stgAddr(stgAddr), .stgWdata(stgWdata),
    .stgReady(stgReady), .stgRdata(stgRdata),
    .srcAcc(srcAcc), .dstAcc(dstAcc), .lastStep(lastStep)
  );

endmodule

// File: rtl/zsp_engine_check.sv
module zsp_engine_check #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              dirWrite,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              done,
  input logic              depValid,
  input logic              depWrite,
  input logic [ADDR_W-1:0] depAddr,
  input logic              depReady,
  input logic              stnValid,
  input logic              stnWrite,
  input logic [ADDR_W-1:0] stnAddr,
  input logic              stnReady,
  input logic              stgValid,
  input logic              stgWrite,
  input logic [ADDR_W-1:0] stgAddr,
  input logic              stgReady
);

  AST_ONE_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    $countones({depValid, stnValid, stgValid}) <= 1); // R11

  AST_DEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    depValid && !depReady |=> depValid && $stable(depAddr) && $stable(depWrite)); // R11

  AST_STN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stnValid && !stnReady |=> stnValid && $stable(stnAddr) && $stable(stnWrite)); // R11

  AST_STG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stgValid && !stgReady |=> stgValid && $stable(stgAddr) && $stable(stgWrite)); // R11

  AST_STG_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    stgValid |-> (stgWrite != dirWrite)); // R3

  AST_SURF_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    (depValid && depWrite != dirWrite) || (stnValid && stnWrite != dirWrite) |-> 1'b0); // R3

  AST_NO_DEPTH_STENCIL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    busy && mode == 2'd0 |-> !depValid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R2

endmodule

bind zsp_engine zsp_engine_check #(.ADDR_W(ADDR_W)) u_check (
  .clk(clk), .rstN(rstN), .dirWrite(dirWrite), .mode(mode), .busy(busy), .done(done),
  .depValid(depValid), .depWrite(depWrite), .depAddr(depAddr), .depReady(depReady),
  .stnValid(stnValid), .stnWrite(stnWrite), .stnAddr(stnAddr), .stnReady(stnReady),
  .stgValid(stgValid), .stgWrite(stgWrite), .stgAddr(stgAddr), .stgReady(stgReady)
);

// File: tb/zsp_engine_test.sv
module zsp_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int BW = 5, BH = 3, BD = 2;
  localparam int D_OX = 28, D_OY = 5, D_SR = 3;
  localparam int S_OX = 60, S_OY = 30, S_SR = 4, S_PITCH = 128;
  localparam int G_BASE = 16, G_ROW = 40, G_LAYER = 128;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, dirWrite = 1'b0;
  logic [1:0] mode = 2'd0, depTiling = 2'd0;
  logic [AW-1:0] depPitch = 256;
  logic busy, done;
  logic depValid, depWrite, stnValid, stnWrite, stgValid, stgWrite;
  logic [AW-1:0] depAddr, stnAddr, stgAddr;
  logic [7:0] depWdata, stnWdata, stgWdata, depRdata, stnRdata, stgRdata;
  logic depReady = 1'b1, stnReady = 1'b1, stgReady = 1'b1;
  logic stallOn = 1'b0;

  logic [7:0] depMem [0:8191];
  logic [7:0] stnMem [0:8191];
  logic [7:0] stgMem [0:511];

  int nTests = 0, nFail = 0;
  int nAcc = 0, nDepAcc = 0, nSurfWr = 0, nStgWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zsp_engine #(.ADDR_W(AW), .DIM_W(10), .CRD_W(16)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite), .mode(mode),
    .depTiling(depTiling), .boxW(10'(BW)), .boxH(10'(BH)), .boxD(10'(BD)),
    .depOrgX(16'(D_OX)), .depOrgY(16'(D_OY)), .depSliceRows(16'(D_SR)), .depPitch(depPitch),
    .stnOrgX(16'(S_OX)), .stnOrgY(16'(S_OY)), .stnSliceRows(16'(S_SR)), .stnPitch(AW'(S_PITCH)),
    .stgBase(AW'(G_BASE)), .stgRowStride(AW'(G_ROW)), .stgLayerStride(AW'(G_LAYER)),
    .busy(busy), .done(done),
    .depValid(depValid), .depWrite(depWrite), .depAddr(depAddr), .depWdata(depWdata),
    .depReady(depReady), .depRdata(depRdata),
    .stnValid(stnValid), .stnWrite(stnWrite), .stnAddr(stnAddr), .stnWdata(stnWdata),
    .stnReady(stnReady), .stnRdata(stnRdata),
    .stgValid(stgValid), .stgWrite(stgWrite), .stgAddr(stgAddr), .stgWdata(stgWdata),
    .stgReady(stgReady), .stgRdata(stgRdata)
  );

  assign depRdata = depMem[depAddr[12:0]];
  assign stnRdata = stnMem[stnAddr[12:0]];
  assign stgRdata = stgMem[stgAddr[8:0]];

  always @(negedge clk) begin
    depReady = stallOn ? (($urandom % 3) != 0) : 1'b1;
    stnReady = stallOn ? (($urandom % 3) != 0) : 1'b1;
    stgReady = stallOn ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (depValid && depReady) begin
      nAcc++; nDepAcc++;
      if (depWrite) begin depMem[depAddr[12:0]] = depWdata; nSurfWr++; end
    end
    if (stnValid && stnReady) begin
      nAcc++;
      if (stnWrite) begin stnMem[stnAddr[12:0]] = stnWdata; nSurfWr++; end
    end
    if (stgValid && stgReady) begin
      nAcc++;
      if (stgWrite) begin stgMem[stgAddr[8:0]] = stgWdata; nStgWr++; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int depRef(input int t, input int x, input int y, input int pitch);
    if (t == 1)
      return ((y / 8) * (pitch / 512) + x / 512) * 4096 + (y % 8) * 512 + x % 512;
    if (t == 2)
      return ((y / 32) * (pitch / 128) + x / 128) * 4096 + ((x % 128) / 16) * 512
             + (y % 32) * 16 + x % 16;
    return y * pitch + x;
  endfunction

  function automatic int stnRef(input int x, input int y);
    return ((y / 64) * (S_PITCH / 64) + x / 64) * 4096 + ((x % 64) / 8) * 512
           + ((y % 64) / 8) * 64 + ((y / 4) % 2) * 32 + ((x / 4) % 2) * 16
           + ((y / 2) % 2) * 8 + ((x / 2) % 2) * 4 + (y % 2) * 2 + x % 2;
  endfunction

  function automatic int pat(input int m, input int s, input int r, input int c, input int b);
    return (s * 61 + r * 29 + c * 11 + b * 3 + 7 + m * 13) % 256;
  endfunction

  function automatic int stgRef(input int pix, input int s, input int r, input int c, input int b);
    return G_BASE + s * G_LAYER + r * G_ROW + c * pix + b;
  endfunction

  task automatic runWalk(input bit wr);
    int waited;
    dirWrite = wr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    check("R2 done pulse seen", int'(done), 1);
    @(negedge clk);
    check("R2 done single cycle", int'(done), 0);
    check("R2 busy cleared", int'(busy), 0);
  endtask

  task automatic runCase(input int m, input int t);
    int used, pix, npix, a0, d0, sw0, gw0;
    used = (m == 1) ? 3 : (m == 2) ? 4 : 0;
    pix  = (m == 1) ? 4 : (m == 2) ? 8 : 1;
    npix = BW * BH * BD;
    mode = 2'(m); depTiling = 2'(t);
    depPitch = (t == 1) ? AW'(512) : AW'(256);
    for (int a = 0; a < 8192; a++) begin
      depMem[a] = 8'((a * 7 + 3) % 256);
      stnMem[a] = 8'((a * 5 + 1) % 256);
    end
    for (int a = 0; a < 512; a++) stgMem[a] = 8'h5A;
    for (int s = 0; s < BD; s++)
      for (int r = 0; r < BH; r++)
        for (int c = 0; c < BW; c++)
          for (int b = 0; b < pix; b++)
            stgMem[stgRef(pix, s, r, c, b)] = 8'(pat(m, s, r, c, b));

    // write pass: staging -> surfaces
    a0 = nAcc; d0 = nDepAcc; gw0 = nStgWr;
    runWalk(1'b1);
    check("R11 transfer count write", nAcc - a0, 2 * npix * (used + 1));
    check("R3 no staging write in write mode", nStgWr - gw0, 0);
    if (m == 0) check("R7 no depth requests", nDepAcc - d0, 0);
    for (int s = 0; s < BD; s++)
      for (int r = 0; r < BH; r++)
        for (int c = 0; c < BW; c++) begin
          int x, y, a;
          for (int b = 0; b < used; b++) begin
            x = (D_OX + c) * 4 + b; y = D_OY + s * D_SR + r;
            a = depRef(t, x, y, int'(depPitch));
            check((m == 1) ? "R4 R9 R10 depth byte" : "R5 R9 R10 depth byte",
                  int'(depMem[a]), pat(m, s, r, c, b));
          end
          if (m == 1) begin
            x = (D_OX + c) * 4 + 3; y = D_OY + s * D_SR + r;
            a = depRef(t, x, y, int'(depPitch));
            check("R6 depth byte 3 kept", int'(depMem[a]), (a * 7 + 3) % 256);
          end
          a = stnRef(S_OX + c, S_OY + s * S_SR + r);
          check("R8 R10 stencil byte", int'(stnMem[a]), pat(m, s, r, c, used));
        end

    // read pass: surfaces -> staging
    for (int a = 0; a < 512; a++) stgMem[a] = 8'hEE;
    a0 = nAcc; sw0 = nSurfWr;
    runWalk(1'b0);
    check("R11 transfer count read", nAcc - a0, 2 * npix * (used + 1));
    check("R3 no surface write in read mode", nSurfWr - sw0, 0);
    for (int s = 0; s < BD; s++)
      for (int r = 0; r < BH; r++)
        for (int c = 0; c < BW; c++) begin
          for (int b = 0; b <= used; b++)
            check("R12 round trip byte", int'(stgMem[stgRef(pix, s, r, c, b)]),
                  pat(m, s, r, c, b));
          for (int b = used + 1; b < pix; b++)
            check("R5 padding bytes untouched", int'(stgMem[stgRef(pix, s, r, c, b)]), 8'hEE);
        end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    check("R1 no requests at reset", int'({depValid, stnValid, stgValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    stallOn = 1'b1;
    for (int m = 1; m <= 2; m++)
      for (int t = 0; t <= 2; t++) runCase(m, t);
    runCase(0, 0);
    stallOn = 1'b0;
    runCase(1, 2);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule